// File: doc/BRIEF.md
# Dual-Channel Timer Compare Unit

This block is an 8-bit up-counter with two compare channels, A and B. On each enabled clock cycle both channels compare the counter against their own compare register. When a channel matches, it sets its sticky match flag and changes its waveform pin according to that channel's pin action field. A flag raises that channel's interrupt line when the matching bit of the interrupt mask is set. The counter also has a sticky overflow flag with its own interrupt line.

The mode input selects how the counter sets its period. In free-running mode the counter runs from 0 to 255 and then starts again at 0. In period-from-A mode it returns to 0 on the enabled cycle after it equals channel A's compare value, so channel A sets the period. Channel B's compare value never sets the period.

Software uses a plain register write port. The port has no ready signal and never stalls, so every write strobe is accepted in its own cycle. A write updates its register at that clock edge. The clock-enable input advances the counter and gates all compare events.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter, both compare registers, the pin action fields and the interrupt mask are all 0. `pin_a`, `pin_b`, `flags` and all three interrupt lines are low.
- R2: In free-running mode (`top_from_a`=0) the counter advances by one on each cycle with `cnt_en` high and goes from 255 to 0. It holds its value on each cycle with `cnt_en` low.
- R3: When `cnt_en` is high and the counter equals a channel's compare value, that channel's flag is set at the next clock edge (`flags` bit 0 for A, bit 1 for B). The two channels act independently of each other.
- R4: Each interrupt line is high exactly while its flag and its mask bit are both set. The mask is at address 3: bit 0 for A, bit 1 for B, bit 2 for overflow.
- R5: In period-from-A mode (`top_from_a`=1), an enabled cycle with the counter equal to channel A's compare value loads 0 at the next edge. Channel B's compare value has no effect on the period.
- R6: The overflow flag (`flags` bit 2) is set only when an enabled cycle moves the counter from 255 to 0, in either mode.
- R7: The pin action field is at address 2, with bits [1:0] for A and [3:2] for B. On a match, 01 toggles the pin, 10 drives it low and 11 drives it high. With 00 the pin output is held low and a match leaves the pin's stored level unchanged.
- R8: Flags stay set until software clears them. Writing a 1 to a bit at address 4 clears that flag. A match in the same cycle as the clear leaves the flag set.
- R9: A write to a compare register (address 0 for A, address 1 for B) takes effect at that clock edge. That channel produces no match in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Clock enable that advances the counter and gates compare events |
| top_from_a | input | 1 | 1 selects period-from-A mode, 0 selects free-running mode |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 3 | Register address: 0 compare A, 1 compare B, 2 pin actions, 3 interrupt mask, 4 flag clear |
| wr_data | input | 8 | Write data |
| pin_a | output | 1 | Channel A waveform pin |
| pin_b | output | 1 | Channel B waveform pin |
| flags | output | 3 | Sticky flags: bit 0 match A, bit 1 match B, bit 2 overflow |
| irq_a | output | 1 | Channel A interrupt request |
| irq_b | output | 1 | Channel B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The counter itself is not visible at the ports. A wrong count therefore shows up as a match flag, a pin edge or the overflow flag arriving in the wrong cycle, often only one period later, which can be as much as 256 enabled cycles. A bad flag or pin register is visible at once: the next sampled cycle shows the wrong value on `flags`, the pins or the interrupt lines. The bench runs a behavioural model alongside the design and compares every output on every cycle, so the first wrong edge is reported in the cycle it happens.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int AW = 3;

  localparam logic [AW-1:0] ADDR_CMP_A = 3'd0;
  localparam logic [AW-1:0] ADDR_CMP_B = 3'd1;
  localparam logic [AW-1:0] ADDR_PINS  = 3'd2;
  localparam logic [AW-1:0] ADDR_MASK  = 3'd3;
  localparam logic [AW-1:0] ADDR_CLR   = 3'd4;

  typedef enum logic [1:0] {
    PIN_OFF    = 2'b00,
    PIN_TOGGLE = 2'b01,
    PIN_LOW    = 2'b10,
    PIN_HIGH   = 2'b11
  } pin_act_e;
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_timer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cmp_a,
  output logic [DW-1:0] cmp_b,
  output pin_act_e      act_a,
  output pin_act_e      act_b,
  output logic [2:0]    mask,
  output logic [1:0]    cmp_wr,
  output logic [2:0]    clr
);
  always_comb begin
    cmp_wr[0] = wr_en && (wr_addr == ADDR_CMP_A);
    cmp_wr[1] = wr_en && (wr_addr == ADDR_CMP_B);
    clr       = (wr_en && (wr_addr == ADDR_CLR)) ? wr_data[2:0] : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a <= '0;
      cmp_b <= '0;
      act_a <= PIN_OFF;
      act_b <= PIN_OFF;
      mask  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CMP_A: cmp_a <= wr_data;
        ADDR_CMP_B: cmp_b <= wr_data;
        ADDR_PINS: begin
          act_a <= pin_act_e'(wr_data[1:0]);
          act_b <= pin_act_e'(wr_data[3:2]);
        end
        ADDR_MASK: mask <= wr_data[2:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmp_counter.sv
module cmp_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          top_mode,
  input  logic [DW-1:0] top_val,
  output logic [DW-1:0] cnt,
  output logic          wrap
);
  localparam logic [DW-1:0] CNT_MAX = '1;

  logic at_top;

  always_comb begin
    wrap   = tick && (cnt == CNT_MAX);
    at_top = top_mode && (cnt == top_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= at_top ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_timer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] cmp,
  input  logic          cmp_wr,
  input  pin_act_e      act,
  input  logic          clr,
  input  logic          irq_en,
  output logic          pin,
  output logic          flag,
  output logic          irq
);
  logic hit;
  logic pin_q;

  assign hit = tick && (cnt == cmp) && !cmp_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      flag <= (flag && !clr) || hit;
      if (hit) begin
        case (act)
          PIN_TOGGLE: pin_q <= !pin_q;
          PIN_LOW:    pin_q <= 1'b0;
          PIN_HIGH:   pin_q <= 1'b1;
          default:    pin_q <= pin_q;
        endcase
      end
    end
  end

  assign pin = pin_q && (act != PIN_OFF);
  assign irq = flag && irq_en;
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          top_from_a,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          pin_a,
  output logic          pin_b,
  output logic [2:0]    flags,
  output logic          irq_a,
  output logic          irq_b,
  output logic          irq_ovf
);
  localparam int NCH = 2;

  logic [DW-1:0] cnt_val;
  logic [DW-1:0] cmp_a_val;
  logic [DW-1:0] cmp_b_val;
  logic          wrap;
  logic          ovf_q;
  pin_act_e      act_a;
  pin_act_e      act_b;
  logic [2:0]    mask;
  logic [1:0]    cmp_wr;
  logic [2:0]    clr;

  logic [DW-1:0] cmp_arr [NCH];
  pin_act_e      act_arr [NCH];
  logic [NCH-1:0] pin_w, flag_w, irq_w;

  cmp_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_a(cmp_a_val), .cmp_b(cmp_b_val), .act_a(act_a), .act_b(act_b),
    .mask(mask), .cmp_wr(cmp_wr), .clr(clr)
  );

  cmp_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_en), .top_mode(top_from_a),
    .top_val(cmp_a_val), .cnt(cnt_val), .wrap(wrap)
  );

  assign cmp_arr[0] = cmp_a_val;
  assign cmp_arr[1] = cmp_b_val;
  assign act_arr[0] = act_a;
  assign act_arr[1] = act_b;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cmp_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(cnt_en), .cnt(cnt_val),
      .cmp(cmp_arr[i]), .cmp_wr(cmp_wr[i]), .act(act_arr[i]),
      .clr(clr[i]), .irq_en(mask[i]),
      .pin(pin_w[i]), .flag(flag_w[i]), .irq(irq_w[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= (ovf_q && !clr[2]) || wrap;
  end

  assign pin_a   = pin_w[0];
  assign pin_b   = pin_w[1];
  assign flags   = {ovf_q, flag_w};
  assign irq_a   = irq_w[0];
  assign irq_b   = irq_w[1];
  assign irq_ovf = ovf_q && mask[2];
endmodule

// File: rtl/cmp_timer_checker.sv
module cmp_timer_checker
  import cmp_timer_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          top_from_a,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] cnt_val,
  input logic [DW-1:0] cmp_a_val,
  input logic [DW-1:0] cmp_b_val,
  input logic [2:0]    flags
);
  localparam logic [DW-1:0] CNT_MAX = '1;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_val)); // R2

  AST_MATCH_SETS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt_val == cmp_b_val && !(wr_en && wr_addr == ADDR_CMP_B)) |=> flags[1]); // R3

  AST_TOP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && top_from_a && cnt_val == cmp_a_val) |=> (cnt_val == '0)); // R5

  AST_WRAP_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt_val == CNT_MAX) |=> flags[2]); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(wr_en && wr_addr == ADDR_CLR && wr_data[0])) |=> flags[0]); // R8
endmodule

bind dual_cmp_timer cmp_timer_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .top_from_a(top_from_a),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cnt_val(cnt_val),
  .cmp_a_val(cmp_a_val), .cmp_b_val(cmp_b_val), .flags(flags)
);

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       top_from_a = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pin_a, pin_b, irq_a, irq_b, irq_ovf;
  logic [2:0] flags;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string req = "R1";

  // behavioural reference state
  int m_cnt, m_ca, m_cb, m_acta, m_actb, m_mask, m_fa, m_fb, m_fo, m_pa, m_pb;

  always #4 clk = !clk;

  dual_cmp_timer dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .top_from_a(top_from_a),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_a(pin_a), .pin_b(pin_b), .flags(flags),
    .irq_a(irq_a), .irq_b(irq_b), .irq_ovf(irq_ovf)
  );

  task automatic check(input string r, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", r, what, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    check(req, "pin_a R7", int'(pin_a), ((m_acta != 0) && m_pa != 0) ? 1 : 0);
    check(req, "pin_b R7", int'(pin_b), ((m_actb != 0) && m_pb != 0) ? 1 : 0);
    check(req, "flag_a R3", int'(flags[0]), m_fa);
    check(req, "flag_b R3", int'(flags[1]), m_fb);
    check(req, "flag_ovf R6", int'(flags[2]), m_fo);
    check(req, "irq R4", int'({irq_ovf, irq_b, irq_a}),
          (m_fo & (m_mask >> 2) & 1) * 4 + (m_fb & (m_mask >> 1) & 1) * 2 + (m_fa & m_mask & 1));
  endtask

  function automatic int pin_next(input int act, input int p);
    case (act)
      1: return 1 - p;
      2: return 0;
      3: return 1;
      default: return p;
    endcase
  endfunction

  task automatic model_step(input int en, input int wm, input int we, input int wa, input int wd);
    int hit_a, hit_b, wrap, clr;
    hit_a = (en != 0 && m_cnt == m_ca && !(we != 0 && wa == 0)) ? 1 : 0;
    hit_b = (en != 0 && m_cnt == m_cb && !(we != 0 && wa == 1)) ? 1 : 0;
    wrap  = (en != 0 && m_cnt == 255) ? 1 : 0;
    clr   = (we != 0 && wa == 4) ? (wd & 7) : 0;
    if (hit_a != 0) m_pa = pin_next(m_acta, m_pa);
    if (hit_b != 0) m_pb = pin_next(m_actb, m_pb);
    m_fa = ((m_fa != 0 && (clr & 1) == 0) || hit_a != 0) ? 1 : 0;
    m_fb = ((m_fb != 0 && (clr & 2) == 0) || hit_b != 0) ? 1 : 0;
    m_fo = ((m_fo != 0 && (clr & 4) == 0) || wrap != 0) ? 1 : 0;
    if (en != 0) m_cnt = (wm != 0 && m_cnt == m_ca) ? 0 : (m_cnt + 1) % 256;
    if (we != 0) begin
      case (wa)
        0: m_ca = wd;
        1: m_cb = wd;
        2: begin m_acta = wd & 3; m_actb = (wd >> 2) & 3; end
        3: m_mask = wd & 7;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input int en, input int wm, input int we, input int wa, input int wd);
    cnt_en = en[0]; top_from_a = wm[0]; wr_en = we[0];
    wr_addr = wa[2:0]; wr_data = wd[7:0];
    @(posedge clk);
    model_step(en, wm, we, wa, wd);
    @(negedge clk);
    cycles++;
    compare_all();
  endtask

  task automatic wr(input int wm, input int wa, input int wd);
    cyc(0, wm, 1, wa, wd);
  endtask

  task automatic run(input int n, input int en, input int wm);
    for (int i = 0; i < n; i++) cyc(en, wm, 0, 0, 0);
  endtask

  initial begin
    m_cnt = 0; m_ca = 0; m_cb = 0; m_acta = 0; m_actb = 0; m_mask = 0;
    m_fa = 0; m_fb = 0; m_fo = 0; m_pa = 0; m_pb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req = "R1";
    check("R1", "flags after reset", int'(flags), 0);
    check("R1", "pins after reset", int'({pin_b, pin_a}), 0);
    check("R1", "irqs after reset", int'({irq_ovf, irq_b, irq_a}), 0);

    // R2/R3/R6: free running, toggle A, set B
    req = "R2";
    wr(0, 3, 7);
    wr(0, 2, 1 | (3 << 2));
    wr(0, 0, 10);
    wr(0, 1, 20);
    run(600, 1, 0);
    for (int i = 0; i < 300; i++) cyc(i % 2, 0, 0, 0, 0);
    for (int i = 0; i < 200; i++) cyc((i % 3 == 0) ? 1 : 0, 0, 0, 0, 0);

    // R8: clears every cycle; a clear landing on a match must lose
    req = "R8";
    for (int i = 0; i < 300; i++) cyc(1, 0, 1, 4, 7);
    run(50, 1, 0);
    wr(0, 4, 2);
    wr(0, 4, 5);

    // R9: rewrite compare A with the current count each cycle
    req = "R9";
    wr(0, 4, 7);
    for (int i = 0; i < 300; i++) cyc(1, 0, 1, 0, m_cnt);
    for (int i = 0; i < 300; i++) cyc(1, 0, 1, 1, (m_cnt + 1) % 256);

    // R5: period set by A, B never sets the period
    req = "R5";
    wr(0, 0, 5);
    wr(0, 1, 3);
    wr(0, 4, 7);
    run(100, 1, 1);
    wr(1, 1, 200);
    run(100, 1, 1);
    wr(1, 0, 255);
    run(600, 1, 1);

    // R7: pin actions, including disconnected
    req = "R7";
    wr(0, 0, 40);
    wr(0, 1, 90);
    wr(0, 2, 0);
    run(300, 1, 0);
    wr(0, 2, 2 | (1 << 2));
    run(300, 1, 0);
    wr(0, 2, 3 | (2 << 2));
    run(300, 1, 0);

    // R4: mask combinations
    req = "R4";
    wr(0, 3, 1);
    run(100, 1, 0);
    wr(0, 3, 6);
    run(300, 1, 0);
    wr(0, 3, 0);
    run(20, 1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired in phase %s", req);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule